// File: doc/BRIEF.md
# Index Register and Branch Unit

This unit holds seven 15-bit index registers for a word-addressed processor core. It also performs the index arithmetic that the instruction sequencer needs. Each cycle it takes an operation code, a 3-bit register tag, the instruction's address and decrement fields, the accumulator's address field, a 15-bit field read from memory and the current instruction counter. From these it forms outputs that depend only on the current inputs and the present register contents:

- the effective address;
- a branch-taken flag;
- the branch target;
- the negated (complemented) value of the selected register, which store-type operations write out.

Registers are loaded in complemented form, meaning 2^15 minus a value. Tag 0 names no register: a read with tag 0 returns zero and a write with tag 0 is dropped. Any register update takes effect at the next rising clock edge, so every output in the cycle of the update still reflects the old contents. All index arithmetic wraps modulo 2^15. Memory access and the accumulator datapath belong to neighbouring blocks.

Top module: `idx_unit`

## Requirements
- R1: After reset every index register reads as zero, so the effective address equals the address field for every tag.
- R2: The effective address is (address field + selected register) mod 2^15; with tag 0 it equals the address field.
- R3: Operation code 1 (immediate complement) writes (2^15 − address field) mod 2^15 into the tagged register at the clock edge; outputs in that same cycle still use the old value; a zero address field leaves zero.
- R4: Operation code 2 (memory complement) writes (2^15 − memory field) mod 2^15 into the tagged register.
- R5: Operation code 3 (accumulator complement) writes (2^15 − accumulator address field) mod 2^15 into the tagged register.
- R6: Operation code 4 (step and jump) adds the decrement field to the tagged register modulo 2^15, raises the taken flag and targets the address field.
- R7: Operation code 5 (call) writes (2^15 − instruction counter) into the tagged register, raises the taken flag and targets the address field.
- R8: Operation code 6 (test high) raises the taken flag exactly when the decrement field is less than the selected register (unsigned), targeting the address field.
- R9: Operation code 7 (test low) raises the taken flag exactly when the decrement field is greater than or equal to the selected register (unsigned).
- R10: Operation code 8 (jump) always raises the taken flag and targets the effective address.
- R11: The complement output equals (2^15 − selected register) mod 2^15, and is 0 for tag 0.
- R12: A write with tag 0 changes no register, and a write to one tag leaves the other registers unchanged.
- R13: Operation code 0 and codes 9 to 15 change no register and keep the taken flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code |
| tag | input | 3 | Index register select, 0 = none |
| addr | input | 15 | Address field of the instruction |
| decr | input | 15 | Decrement field of the instruction |
| acc_field | input | 15 | Accumulator address field |
| mem_field | input | 15 | Address field of the word read from memory |
| ic | input | 15 | Current instruction counter |
| ea | output | 15 | Effective address |
| br_taken | output | 1 | Branch taken |
| br_target | output | 15 | Branch target |
| xr_cmpl | output | 15 | Complement of the selected register |

## Verification
A single vector walk tries the index path in several ways:

- Loads come from each of the three complement sources, followed by a read of the same register in the next cycle. This separates the immediate, memory and accumulator paths and shows whether the write was applied.
- The two test operations are run with decrement values one below and equal to the register. This exposes a wrong comparison direction or strictness.
- Increments that wrap past 2^15, and a complement of zero, expose missing modulo arithmetic.
- Writes with tag 0 and with undefined codes, followed by read-backs of other tags, show that nothing stray reached a register.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int ADDR_W = 15;
    localparam int TAG_W  = 3;
    localparam int NUM_XR = 7;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_IMMC = 4'd1,
        OP_MEMC = 4'd2,
        OP_ACCC = 4'd3,
        OP_STEP = 4'd4,
        OP_CALL = 4'd5,
        OP_TSTH = 4'd6,
        OP_TSTL = 4'd7,
        OP_JMP  = 4'd8
    } idx_op_e;

endpackage

// File: rtl/idx_regfile.sv
module idx_regfile #(
    parameter int AW   = 15,
    parameter int TW   = 3,
    parameter int NREG = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_tag,
    input  logic [AW-1:0] wr_data,
    input  logic [TW-1:0] rd_tag,
    output logic [AW-1:0] rd_data
);

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] xr;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [NREG-1:0] hit;
    logic [NREG-1:0] sel;

    // per-register decode; tag 0 matches no entry
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign hit[i] = wr_en && (wr_tag == TW'(i + 1));
        assign sel[i] = (rd_tag == TW'(i + 1));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                st_d.xr[i] = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                rd_data = st_q.xr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/idx_addr_path.sv
module idx_addr_path #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] xr,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] cmpl
);

    always_comb begin
        ea   = addr + xr;
        cmpl = AW'(0) - xr;
    end

endmodule

// File: rtl/idx_branch.sv
module idx_branch
    import idx_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic [3:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] decr,
    input  logic [AW-1:0] xr,
    input  logic [AW-1:0] ea,
    output logic          taken,
    output logic [AW-1:0] target
);

    logic hi_cond;

    assign hi_cond = (decr < xr);

    always_comb begin
        taken  = 1'b0;
        target = addr;
        case (op)
            OP_STEP,
            OP_CALL: taken = 1'b1;
            OP_TSTH: taken = hi_cond;
            OP_TSTL: taken = !hi_cond;
            OP_JMP: begin
                taken  = 1'b1;
                target = ea;
            end
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/idx_unit.sv
module idx_unit
    import idx_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int TW   = TAG_W,
    parameter int NREG = NUM_XR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op,
    input  logic [TW-1:0] tag,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] decr,
    input  logic [AW-1:0] acc_field,
    input  logic [AW-1:0] mem_field,
    input  logic [AW-1:0] ic,
    output logic [AW-1:0] ea,
    output logic          br_taken,
    output logic [AW-1:0] br_target,
    output logic [AW-1:0] xr_cmpl
);

    typedef struct packed {
        logic          en;
        logic [AW-1:0] data;
    } wr_req_t;

    wr_req_t       wr_d;
    logic [AW-1:0] xr_rd;

    always_comb begin
        wr_d.en   = 1'b1;
        wr_d.data = '0;
        case (op)
            OP_IMMC: wr_d.data = AW'(0) - addr;
            OP_MEMC: wr_d.data = AW'(0) - mem_field;
            OP_ACCC: wr_d.data = AW'(0) - acc_field;
            OP_STEP: wr_d.data = xr_rd + decr;
            OP_CALL: wr_d.data = AW'(0) - ic;
            default: wr_d.en   = 1'b0;
        endcase
        if (tag == '0) begin
            wr_d.en = 1'b0;
        end
    end

    idx_regfile #(.AW(AW), .TW(TW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_d.en),
        .wr_tag  (tag),
        .wr_data (wr_d.data),
        .rd_tag  (tag),
        .rd_data (xr_rd)
    );

    idx_addr_path #(.AW(AW)) u_ap (
        .addr (addr),
        .xr   (xr_rd),
        .ea   (ea),
        .cmpl (xr_cmpl)
    );

    idx_branch #(.AW(AW)) u_br (
        .op     (op),
        .addr   (addr),
        .decr   (decr),
        .xr     (xr_rd),
        .ea     (ea),
        .taken  (br_taken),
        .target (br_target)
    );

endmodule

// File: rtl/idx_unit_chk.sv
module idx_unit_chk
    import idx_pkg::*;
#(
    parameter int AW = 15,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op,
    input logic [TW-1:0] tag,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] decr,
    input logic [AW-1:0] ic,
    input logic [AW-1:0] ea,
    input logic          br_taken,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] xr_cmpl
);

    // R3
    imm_load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IMMC && tag != '0) |=>
            (tag != $past(tag)) || (ea == AW'(addr - $past(addr))));

    // R7
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL && tag != '0) |=>
            (tag != $past(tag)) || (ea == AW'(addr - $past(ic))));

    // R6
    step_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |-> (br_taken && br_target == addr));

    // R8
    test_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TSTH) |-> (br_taken == (decr < AW'(ea - addr))));

    // R9
    test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TSTL) |-> (br_taken == (decr >= AW'(ea - addr))));

    // R10
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JMP) |-> (br_taken && br_target == ea));

    // R11
    no_reg_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag == '0) |-> (xr_cmpl == '0 && ea == addr));

    // R11
    cmpl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(xr_cmpl + (ea - addr)) == '0);

    // R13
    idle_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP || op > 4'd8) |-> !br_taken);

endmodule

bind idx_unit idx_unit_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .tag       (tag),
    .addr      (addr),
    .decr      (decr),
    .ic        (ic),
    .ea        (ea),
    .br_taken  (br_taken),
    .br_target (br_target),
    .xr_cmpl   (xr_cmpl)
);

// File: tb/tb_idx_unit.sv
module tb_idx_unit;

    localparam int AW = 15;
    localparam int NV = 24;

    typedef struct packed {
        logic [7:0]    req;
        logic [3:0]    op;
        logic [2:0]    tag;
        logic [AW-1:0] addr;
        logic [AW-1:0] decr;
        logic [AW-1:0] accf;
        logic [AW-1:0] memf;
        logic [AW-1:0] icv;
        logic [AW-1:0] x_ea;
        logic          x_tk;
        logic [AW-1:0] x_tgt;
        logic [AW-1:0] x_cm;
    } vec_t;

    // fields: req, op, tag, addr, decr, acc, mem, ic, ea, taken, target, cmpl
    localparam vec_t VEC [NV] = '{
        '{8'd3,  4'd1, 3'd1, 15'h0010, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0010, 1'b0, 15'h0010, 15'h0000}, // R3 old value
        '{8'd3,  4'd0, 3'd1, 15'h0020, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0010, 1'b0, 15'h0020, 15'h0010}, // R3 R2 wrap
        '{8'd4,  4'd2, 3'd2, 15'h0100, 15'h0000, 15'h0000, 15'h0003, 15'h0000, 15'h0100, 1'b0, 15'h0100, 15'h0000}, // R4
        '{8'd5,  4'd3, 3'd3, 15'h0000, 15'h0000, 15'h1234, 15'h0000, 15'h0000, 15'h0000, 1'b0, 15'h0000, 15'h0000}, // R5
        '{8'd8,  4'd6, 3'd2, 15'h0200, 15'h7FFC, 15'h0000, 15'h0000, 15'h0000, 15'h01FD, 1'b1, 15'h0200, 15'h0003}, // R8 R4
        '{8'd8,  4'd6, 3'd2, 15'h0200, 15'h7FFD, 15'h0000, 15'h0000, 15'h0000, 15'h01FD, 1'b0, 15'h0200, 15'h0003}, // R8 equal
        '{8'd9,  4'd7, 3'd2, 15'h0200, 15'h7FFD, 15'h0000, 15'h0000, 15'h0000, 15'h01FD, 1'b1, 15'h0200, 15'h0003}, // R9 equal
        '{8'd9,  4'd7, 3'd2, 15'h0200, 15'h7FFC, 15'h0000, 15'h0000, 15'h0000, 15'h01FD, 1'b0, 15'h0200, 15'h0003}, // R9
        '{8'd6,  4'd4, 3'd1, 15'h0300, 15'h0005, 15'h0000, 15'h0000, 15'h0000, 15'h02F0, 1'b1, 15'h0300, 15'h0010}, // R6
        '{8'd10, 4'd8, 3'd1, 15'h0400, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h03F5, 1'b1, 15'h03F5, 15'h000B}, // R10 R6
        '{8'd7,  4'd5, 3'd4, 15'h0500, 15'h0000, 15'h0000, 15'h0000, 15'h0042, 15'h0500, 1'b1, 15'h0500, 15'h0000}, // R7
        '{8'd7,  4'd0, 3'd4, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h7FBE, 1'b0, 15'h0000, 15'h0042}, // R7 R11
        '{8'd12, 4'd1, 3'd0, 15'h0050, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0050, 1'b0, 15'h0050, 15'h0000}, // R12 tag 0
        '{8'd9,  4'd7, 3'd0, 15'h0060, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0060, 1'b1, 15'h0060, 15'h0000}, // R9 tag 0
        '{8'd8,  4'd6, 3'd0, 15'h0060, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0060, 1'b0, 15'h0060, 15'h0000}, // R8 tag 0
        '{8'd12, 4'd0, 3'd1, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h7FF5, 1'b0, 15'h0000, 15'h000B}, // R12 others kept
        '{8'd3,  4'd1, 3'd5, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 1'b0, 15'h0000, 15'h0000}, // R3 zero
        '{8'd3,  4'd0, 3'd5, 15'h0007, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0007, 1'b0, 15'h0007, 15'h0000}, // R3 wraps to 0
        '{8'd6,  4'd4, 3'd3, 15'h0010, 15'h7FFF, 15'h0000, 15'h0000, 15'h0000, 15'h6DDC, 1'b1, 15'h0010, 15'h1234}, // R6 R5
        '{8'd6,  4'd0, 3'd3, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h6DCB, 1'b0, 15'h0000, 15'h1235}, // R6 wrap
        '{8'd13, 4'd15,3'd3, 15'h0001, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h6DCC, 1'b0, 15'h0001, 15'h1235}, // R13
        '{8'd13, 4'd0, 3'd3, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h6DCB, 1'b0, 15'h0000, 15'h1235}, // R13 no write
        '{8'd10, 4'd8, 3'd0, 15'h7ABC, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h7ABC, 1'b1, 15'h7ABC, 15'h0000}, // R10 tag 0
        '{8'd2,  4'd0, 3'd7, 15'h0001, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0001, 1'b0, 15'h0001, 15'h0000}  // R2 R12
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op = '0;
    logic [2:0]    tag = '0;
    logic [AW-1:0] addr = '0, decr = '0, acc_field = '0, mem_field = '0, ic = '0;
    logic [AW-1:0] ea, br_target, xr_cmpl;
    logic          br_taken;
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    idx_unit dut (
        .clk(clk), .rst_n(rst_n), .op(op), .tag(tag), .addr(addr), .decr(decr),
        .acc_field(acc_field), .mem_field(mem_field), .ic(ic),
        .ea(ea), .br_taken(br_taken), .br_target(br_target), .xr_cmpl(xr_cmpl)
    );

    task automatic drive(input vec_t v);
        op = v.op; tag = v.tag; addr = v.addr; decr = v.decr;
        acc_field = v.accf; mem_field = v.memf; ic = v.icv;
    endtask

    task automatic check(input int req, input vec_t v);
        checks++;
        if (ea !== v.x_ea || br_taken !== v.x_tk || br_target !== v.x_tgt || xr_cmpl !== v.x_cm) begin
            errors++;
            $display("FAIL R%0d: ea/tk/tgt/cm got %h/%b/%h/%h expected %h/%b/%h/%h",
                     req, ea, br_taken, br_target, xr_cmpl, v.x_ea, v.x_tk, v.x_tgt, v.x_cm);
        end
    endtask

    task automatic idle_read(input int req, input logic [2:0] t, input logic [AW-1:0] a,
                             input logic [AW-1:0] x_ea);
        vec_t v;
        v = '0;
        v.tag = t; v.addr = a; v.x_ea = x_ea; v.x_tgt = a; v.x_cm = AW'(0) - AW'(x_ea - a);
        @(negedge clk); drive(v); #3; check(req, v);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through every tag
        for (int t = 0; t < 8; t++) begin
            idle_read(1, 3'(t), 15'h0123, 15'h0123);
        end
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #3;
            check(int'(VEC[i].req), VEC[i]);
        end
        // R1: reset in mid-run clears loaded registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_read(1, 3'd1, 15'h0040, 15'h0040);
        idle_read(1, 3'd3, 15'h0040, 15'h0040);
        // R4: memory complement of zero keeps zero, of max gives one
        begin
            vec_t v;
            v = '0; v.op = 4'd2; v.tag = 3'd6; v.memf = 15'h7FFF;
            v.x_ea = 15'h0000; v.x_tgt = 15'h0000; v.x_cm = 15'h0000;
            @(negedge clk); drive(v); #3; check(4, v);
        end
        idle_read(4, 3'd6, 15'h0000, 15'h0001);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule